// File: doc/BRIEF.md
# Outer-Product Int8 Multiply-Accumulate Array

This block is the compute core of a matrix engine. It holds a tile of 8×8 signed 32-bit running sums. On each enabled cycle it takes eight 32-bit weight words and eight 32-bit activation words. Every word packs four signed int8 lanes.

Weight word `r` is shared by all eight cells of row `r`. Activation word `c` is shared by all eight cells of column `c`. Each cell forms the four-lane dot product of its row weight and its column activation and adds it to its sum. One cycle therefore does 256 multiply-accumulates from 16 operand words.

A clear input empties the tile. When clear and accumulate are raised together, each cell starts a fresh sum from the current dot product. A row-select input picks one row, and its eight sums appear combinationally on the read port.

The reset input acts at once and is released to the array through a two-stage synchronizer. Update controls are therefore ignored until two rising edges after `rst_n` goes high.

Top module: `opmac_array`

## Requirements
- R1: While reset is active, and after it until the first update, every accumulator reads 0.
- R2: With `acc_en`=1 and `clr`=0, cell (r,c) adds the dot product of weight word r and activation word c at the rising edge. Lane k of a word is bits [8k+7:8k].
- R3: The running sum wraps modulo 2^32, in both directions, and never saturates.
- R4: With `acc_en`=0 and `clr`=0, every accumulator keeps its value whatever the operand inputs carry.
- R5: With `clr`=1 and `acc_en`=0, all 64 accumulators become 0 at the next rising edge.
- R6: With `clr`=1 and `acc_en`=1, each cell loads its new dot product and discards the old sum.
- R7: `rd_data` bits [32c+31:32c] show accumulator (`rd_row`, c) in the same cycle, with no clock edge needed.
- R8: Lanes are signed two's complement and each product is sign-extended before the sum. For example, four lanes of -128×-128 give 65536, and four lanes of -128×127 give -65024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accumulate enable |
| clr | input | 1 | Clear the tile (starts fresh sums when combined with acc_en) |
| wgt_i | input | 256 | Eight weight words; word r drives row r |
| act_i | input | 256 | Eight activation words; word c drives column c |
| rd_row | input | 3 | Row selected for readout |
| rd_data | output | 256 | Eight sums of the selected row; word c is column c |

## Verification
A wrong dot product, lane order or sign handling shows up on the read port as soon as the edge that folds it in has passed, since the readout has no register. A stuck or leaking enable shows as sums that drift during hold cycles. A wrongly applied clear leaves stale sums in cells that should restart. A wrap error stays hidden until a sum crosses zero or 2^32. The bench therefore drives sums across both boundaries and compares all 64 cells against an arithmetic model after each step.

// File: rtl/opmac_pkg.sv
package opmac_pkg;
  parameter int ROWS  = 8;
  parameter int COLS  = 8;
  parameter int LANES = 4;
  parameter int EW    = 8;
  parameter int AW    = 32;
  localparam int WW   = LANES * EW;
  localparam int RSW  = $clog2(ROWS);
endpackage

// File: rtl/opmac_rst_sync.sv
module opmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/opmac_dot4.sv
module opmac_dot4 #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int AW    = 32
) (
  input  logic [LANES*EW-1:0] w_i,
  input  logic [LANES*EW-1:0] a_i,
  output logic [AW-1:0]       dot_o
);
  localparam int PW = 2 * EW;

  logic signed [PW-1:0] prod [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign prod[k] = $signed(w_i[k*EW +: EW]) * $signed(a_i[k*EW +: EW]);
  end

  always_comb begin
    dot_o = '0;
    for (int k = 0; k < LANES; k++) begin
      dot_o = dot_o + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
    end
  end
endmodule

// File: rtl/opmac_cell.sv
module opmac_cell #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                srst_n,
  input  logic                acc_en,
  input  logic                clr,
  input  logic [LANES*EW-1:0] w_i,
  input  logic [LANES*EW-1:0] a_i,
  output logic [AW-1:0]       acc_o
);
  logic [AW-1:0] dot;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic          acc_ce;

  opmac_dot4 #(.LANES(LANES), .EW(EW), .AW(AW)) u_dot (
    .w_i  (w_i),
    .a_i  (a_i),
    .dot_o(dot)
  );

  always_comb begin
    acc_ce = acc_en | clr;
    acc_d  = acc_q;
    if (clr && acc_en)  acc_d = dot;
    else if (clr)       acc_d = '0;
    else if (acc_en)    acc_d = acc_q + dot;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/opmac_array.sv
module opmac_array
  import opmac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 clr,
  input  logic [ROWS*WW-1:0]   wgt_i,
  input  logic [COLS*WW-1:0]   act_i,
  input  logic [RSW-1:0]       rd_row,
  output logic [COLS*AW-1:0]   rd_data
);
  localparam int ROW_BITS = COLS * AW;

  logic                      srst_n;
  logic [ROWS*ROW_BITS-1:0]  acc_flat;

  opmac_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      opmac_cell #(.LANES(LANES), .EW(EW), .AW(AW)) u_cell (
        .clk   (clk),
        .srst_n(srst_n),
        .acc_en(acc_en),
        .clr   (clr),
        .w_i   (wgt_i[r*WW +: WW]),
        .a_i   (act_i[c*WW +: WW]),
        .acc_o (acc_flat[(r*COLS+c)*AW +: AW])
      );
    end
  end

  always_comb begin
    rd_data = acc_flat[int'(rd_row)*ROW_BITS +: ROW_BITS];
  end
endmodule

// File: rtl/opmac_array_chk.sv
module opmac_array_chk
  import opmac_pkg::*;
(
  input logic                       clk,
  input logic                       srst_n,
  input logic                       acc_en,
  input logic                       clr,
  input logic [COLS*WW-1:0]         act_i,
  input logic [RSW-1:0]             rd_row,
  input logic [COLS*AW-1:0]         rd_data,
  input logic [ROWS*COLS*AW-1:0]    acc_flat
);
  // R1: array held at zero while the synchronized reset is low
  a_r1_reset_zero: assert property (@(posedge clk)
    !srst_n |-> acc_flat == '0);

  // R4: no update without enable or clear
  a_r4_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!acc_en && !clr) |=> $stable(acc_flat));

  // R5: plain clear empties every cell
  a_r5_clear: assert property (@(posedge clk) disable iff (!srst_n)
    (clr && !acc_en) |=> acc_flat == '0);

  // R2: a zero activation vector adds nothing
  a_r2_zero_act: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && !clr && act_i == '0) |=> $stable(acc_flat));

  // R6: fresh start with zero activations lands at zero
  a_r6_fresh_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && clr && act_i == '0) |=> acc_flat == '0);

  // R7: row 0 readout matches the first row of cells
  a_r7_row0: assert property (@(posedge clk) disable iff (!srst_n)
    rd_row == '0 |-> rd_data == acc_flat[COLS*AW-1:0]);
endmodule

bind opmac_array opmac_array_chk u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .acc_en  (acc_en),
  .clr     (clr),
  .act_i   (act_i),
  .rd_row  (rd_row),
  .rd_data (rd_data),
  .acc_flat(acc_flat)
);

// File: tb/opmac_array_test.sv
`timescale 1ns/1ps
module opmac_array_test;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic         acc_en;
  logic         clr;
  logic [255:0] wgt_i;
  logic [255:0] act_i;
  logic [2:0]   rd_row;
  logic [255:0] rd_data;

  int total;
  int bad;
  logic [31:0] exp_acc [N][N];

  opmac_array uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .clr(clr),
    .wgt_i(wgt_i), .act_i(act_i), .rd_row(rd_row), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] dot(input logic [31:0] w, input logic [31:0] a);
    int s;
    s = 0;
    for (int k = 0; k < 4; k++) s += int'($signed(w[8*k +: 8])) * int'($signed(a[8*k +: 8]));
    return 32'(s);
  endfunction

  task automatic check_all(input string tag);
    for (int r = 0; r < N; r++) begin
      rd_row = 3'(r);
      #0.2;
      for (int c = 0; c < N; c++) begin
        total++;
        if (rd_data[32*c +: 32] !== exp_acc[r][c]) begin
          bad++;
          $display("FAIL %s cell(%0d,%0d) actual=%h expected=%h", tag, r, c,
                   rd_data[32*c +: 32], exp_acc[r][c]);
        end
      end
    end
  endtask

  task automatic step(input logic en, input logic cl,
                      input logic [255:0] w, input logic [255:0] a);
    @(negedge clk);
    acc_en = en; clr = cl; wgt_i = w; act_i = a;
    @(posedge clk);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        if (cl && en)  exp_acc[r][c] = dot(w[32*r +: 32], a[32*c +: 32]);
        else if (cl)   exp_acc[r][c] = '0;
        else if (en)   exp_acc[r][c] = exp_acc[r][c] + dot(w[32*r +: 32], a[32*c +: 32]);
      end
    @(negedge clk);
    acc_en = 1'b0; clr = 1'b0;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] fill(input logic [7:0] b);
    return {32{b}};
  endfunction

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; acc_en = 1'b0; clr = 1'b0;
    wgt_i = '0; act_i = '0; rd_row = '0;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) exp_acc[r][c] = '0;

    // R1: during reset, with enables toggling
    repeat (3) @(negedge clk);
    acc_en = 1'b1; wgt_i = fill(8'h11); act_i = fill(8'h22);
    check_all("R1 in reset");
    acc_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // R2: varied random operands, accumulated step by step
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, rnd256(), rnd256());
      check_all("R2 accumulate");
    end

    // R2: one hot lane walk to pin lane positions
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, fill(8'h00) | {8{32'(8'h01) << (8*k)}},
           {8{32'(8'h05 + k) << (8*k)}});
      check_all("R2 lane position");
    end

    // R4: hold with changing operands
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0, rnd256(), rnd256());
      check_all("R4 hold");
    end

    // R5: plain clear
    step(1'b1, 1'b0, rnd256(), rnd256());
    step(1'b0, 1'b1, rnd256(), rnd256());
    check_all("R5 clear");

    // R6: clear plus accumulate starts fresh
    step(1'b1, 1'b0, rnd256(), rnd256());
    step(1'b1, 1'b1, rnd256(), rnd256());
    check_all("R6 fresh load");

    // R8: sign extremes
    step(1'b1, 1'b1, fill(8'h80), fill(8'h80));
    check_all("R8 min*min");
    step(1'b1, 1'b1, fill(8'h80), fill(8'h7f));
    check_all("R8 min*max");

    // R3: downward wrap below zero
    step(1'b1, 1'b1, '0, '0);
    step(1'b1, 1'b0, fill(8'h80), fill(8'h7f));
    check_all("R3 wrap below zero");

    // R3: upward wrap past 2^32, 65536 x 65536 plus one more
    step(1'b1, 1'b1, '0, '0);
    @(negedge clk);
    acc_en = 1'b1; wgt_i = fill(8'h80); act_i = fill(8'h80);
    repeat (65537) @(posedge clk);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
      exp_acc[r][c] = 32'(65537 * 65536);
    @(negedge clk);
    acc_en = 1'b0;
    check_all("R3 wrap past top");

    // R7: readout of a patterned tile, rows in reverse order
    step(1'b1, 1'b1, rnd256(), rnd256());
    for (int r = N - 1; r >= 0; r--) begin
      rd_row = 3'(r);
      #0.2;
      for (int c = 0; c < N; c++) begin
        total++;
        if (rd_data[32*c +: 32] !== exp_acc[r][c]) begin
          bad++;
          $display("FAIL R7 readout cell(%0d,%0d) actual=%h expected=%h", r, c,
                   rd_data[32*c +: 32], exp_acc[r][c]);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule